// File: doc/BRIEF.md
# Replay-capable dual-clock FIFO

This block is a dual-clock FIFO whose read side can be rewound. Words written on the write clock are stored in order. They are delivered on the read clock either on request (standard mode) or pre-loaded onto the output register (first-word-fall-through mode). A low level on the retransmit input at a read-clock edge asks the block to move its read pointer back to RAM location zero, so the words already consumed are delivered again from the first one written.

The rewind has two forms, picked by a static input. The normal-latency form runs a two-cycle setup period, during which the read-status flag reports that no word is available. The zero-latency form puts the first word on the data output on the edge that samples the request. A request that breaks the usage rules changes no pointer and raises a one-cycle error pulse. The same applies to a request that arrives while the enables are active in normal-latency form.

Occupancy is reported through three flags. Almost-empty is registered on the read clock. Half-full is derived directly from the read-side pointers. Almost-full is derived from the write-side pointers. Pointers cross between the clocks as Gray codes through two-flop synchronizers.

The read controller is a three-state machine:
- `RD_RUN` is normal operation.
- `RD_SETUP_A` and `RD_SETUP_B` are the two setup cycles of a normal-latency rewind.

It has three transitions:
- `RD_RUN` goes to `RD_SETUP_A` on an accepted normal-latency request.
- `RD_SETUP_A` always goes to `RD_SETUP_B`.
- `RD_SETUP_B` always goes back to `RD_RUN`. In first-word-fall-through mode this step also loads location zero into the output register.

An accepted zero-latency request keeps the machine in `RD_RUN`.

Top module: `rtf_replay_fifo`

## Requirements
- R1: While and after reset, with no traffic: `rd_stat` is 0 in standard mode and 1 in fall-through mode, `ae_n` is 0, `hf_n` is 1, `af_n` is 1 and `rt_err` is 0.
- R2: Writes with `wen_n` low are stored in order and are dropped while DEPTH words are held. In standard mode, `ren_n` low at a read-clock edge with a word available puts the next word on `dout` after that edge. `rd_stat` is 1 exactly when a word is available.
- R3: In fall-through mode (`mode_fwft` = 1), the oldest word appears on `dout` with no read request and `rd_stat` goes to 0. Each later `ren_n` low edge advances `dout` to the next word.
- R4: An accepted request moves the read pointer to location 0. The words are then delivered again from the first word written since reset, in write order.
- R5: Standard mode, normal latency (`rt_zero_lat` = 0): `rd_stat` is 0 after the accepting edge and after the next edge. It is 1 after the second edge following it. Each replayed word, the first included, needs `ren_n` low.
- R6: Fall-through mode, normal latency: `rd_stat` is 1 after the accepting edge and after the next edge. After the second edge following it, `rd_stat` is 0 and the first word is on `dout`.
- R7: Zero latency (`rt_zero_lat` = 1): the first word is on `dout` after the accepting edge itself, and `ren_n` may be low on that edge. `rd_stat` then shows a word available (1 in standard mode, 0 in fall-through mode).
- R8: Read-side occupancy is the words written (as seen through the synchronizer) minus the words taken from RAM, plus one if the fall-through output register holds a word. `ae_n` is 0 when that count is at most AE_OFS. It follows the count two read-clock edges late, so after a rewind it changes on the second edge after the accepting edge.
- R9: `hf_n` is 0 when the read-side occupancy exceeds DEPTH/2. It changes right after the accepting edge.
- R10: `af_n` is 0 when the write-side occupancy (written minus the synchronized read pointer) is at least DEPTH-AF_OFS. After a rewind it changes on the second write-clock edge after the accepting edge.
- R11: In normal latency, a request with `ren_n` low, or with `wen_n` low as seen through a two-flop synchronizer, is rejected. `rt_err` is 1 for the following cycle, the pointers do not rewind, and a read requested on that edge still takes place.
- R12: A request is rejected with an `rt_err` pulse in either of two cases. The first is when fewer than 2 words have been consumed since reset or the last rewind. The second is when more than DEPTH-2 words (standard) or DEPTH-1 words (fall-through) have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_fwft | input | 1 | 1 selects first-word-fall-through; static outside reset |
| rt_zero_lat | input | 1 | 1 selects zero-latency rewind; static outside reset |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Active-low write enable |
| din | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Active-low read enable |
| rt_n | input | 1 | Active-low retransmit request, sampled on `rclk` |
| dout | output | DW | Output data register |
| rd_stat | output | 1 | Standard mode: low when empty. Fall-through mode: low when `dout` holds a word |
| ae_n | output | 1 | Active-low almost-empty, registered on `rclk` |
| hf_n | output | 1 | Active-low half-full |
| af_n | output | 1 | Active-low almost-full |
| rt_err | output | 1 | One-cycle pulse for a rejected retransmit request |

## Verification
A read pointer left wrong after a rewind shows on `dout` at the first replayed word. That is one cycle later in standard mode and up to three cycles later in fall-through mode, because word zero is compared against its written value. A setup sequence of the wrong length moves the edge on `rd_stat` by a cycle, and the bench samples that edge at each of the two setup cycles. Flag pipelines of the wrong depth show up one edge early or late on `ae_n` and `af_n`, because both are sampled on the first and the second edge after the request. A count or enable rule applied wrongly shows up as a missing or extra `rt_err` pulse together with an unexpected word on `dout`.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

    typedef enum logic [1:0] {
        RD_RUN     = 2'd0,
        RD_SETUP_A = 2'd1,
        RD_SETUP_B = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rtf_sync.sv
module rtf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/rtf_store.sv
module rtf_store #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/rtf_wr_side.sv
module rtf_wr_side #(
    parameter int AW     = 4,
    parameter int AF_OFS = 4
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          mode_fwft,
    input  logic          wen_n,
    input  logic [AW:0]   rptr_gray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wptr_gray,
    output logic          over_lim,
    output logic          af_n,
    output logic [AW:0]   wocc
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] FULL_V  = PW'(DEPTH);
    localparam logic [PW-1:0] AF_V    = PW'(DEPTH - AF_OFS);
    localparam logic [PW-1:0] LIM_STD = PW'(DEPTH - 2);
    localparam logic [PW-1:0] LIM_FW  = PW'(DEPTH - 1);

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [PW-1:0] wbin, wbin_nx, rsync_gray, rsync_bin, lim;

    rtf_sync #(.W(PW)) u_rsync (
        .clk  (wclk),
        .rst_n(rst_n),
        .d    (rptr_gray),
        .q    (rsync_gray)
    );

    assign rsync_bin = gray_to_bin(rsync_gray);
    assign wocc      = wbin - rsync_bin;
    assign we        = !wen_n && (wocc != FULL_V);
    assign waddr     = wbin[AW-1:0];
    assign wbin_nx   = we ? wbin + PW'(1) : wbin;
    assign lim       = mode_fwft ? LIM_FW : LIM_STD;
    assign af_n      = !(wocc >= AF_V);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin      <= '0;
            wptr_gray <= '0;
            over_lim  <= 1'b0;
        end else begin
            wbin      <= wbin_nx;
            wptr_gray <= wbin_nx ^ (wbin_nx >> 1);
            if (we && (wbin == lim)) begin
                over_lim <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtf_rd_side.sv
module rtf_rd_side
    import rtf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int AE_OFS = 2
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mode_fwft,
    input  logic          rt_zero_lat,
    input  logic          ren_n,
    input  logic          rt_n,
    input  logic          wen_n,
    input  logic          over_lim,
    input  logic [AW:0]   wptr_gray,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_gray,
    output logic [AW:0]   rptr,
    output logic [DW-1:0] dout,
    output logic          rd_stat,
    output logic          ae_n,
    output logic          hf_n,
    output logic          rt_err,
    output rd_state_e     st
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW:0]   HALF_V = (PW+1)'(DEPTH / 2);
    localparam logic [PW:0]   AE_V   = (PW+1)'(AE_OFS);
    localparam logic [PW-1:0] MIN_USED = PW'(2);

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // write-domain status brought over to the read clock
    logic [PW+1:0] x_in, x_out;
    logic [PW-1:0] wbin;
    logic          wen_s, over_s;

    assign x_in = {wen_n, over_lim, wptr_gray};

    rtf_sync #(.W(PW + 2)) u_wsync (
        .clk  (rclk),
        .rst_n(rst_n),
        .d    (x_in),
        .q    (x_out)
    );

    assign wen_s  = x_out[PW+1];
    assign over_s = x_out[PW];
    assign wbin   = gray_to_bin(x_out[PW-1:0]);

    rd_state_e     st_nx;
    logic          valid, valid_nx, load;
    logic [PW-1:0] ptr_nx, used;
    logic          ram_empty, held, count_ok, quiet;
    logic          rt_req, rt_take, rt_bad;
    logic [PW:0]   occ, occ_q;

    assign ram_empty = (rptr == wbin);
    assign held      = mode_fwft && valid;
    assign used      = rptr - PW'(held);
    assign count_ok  = !over_s && (used >= MIN_USED);
    assign quiet     = wen_s && (rt_zero_lat || ren_n);
    assign rt_req    = !rt_n;
    assign rt_take   = rt_req && (st == RD_RUN) && count_ok && quiet;
    assign rt_bad    = rt_req && !rt_take;
    assign raddr     = (rt_take && rt_zero_lat) ? '0 : rptr[AW-1:0];
    assign occ       = {1'b0, wbin - rptr} + (PW+1)'(held);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            RD_RUN:     if (rt_take && !rt_zero_lat) st_nx = RD_SETUP_A;
            RD_SETUP_A: st_nx = RD_SETUP_B;
            RD_SETUP_B: st_nx = RD_RUN;
            default:    st_nx = RD_RUN;
        endcase
    end

    // state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RD_RUN;
        end else begin
            st <= st_nx;
        end
    end

    // datapath actions per state
    always_comb begin
        load     = 1'b0;
        ptr_nx   = rptr;
        valid_nx = valid;
        unique case (st)
            RD_RUN: begin
                if (rt_take) begin
                    if (rt_zero_lat) begin
                        load     = 1'b1;
                        ptr_nx   = PW'(1);
                        valid_nx = mode_fwft;
                    end else begin
                        ptr_nx   = '0;
                        valid_nx = 1'b0;
                    end
                end else if (!mode_fwft) begin
                    if (!ren_n && !ram_empty) begin
                        load   = 1'b1;
                        ptr_nx = rptr + PW'(1);
                    end
                end else if (!valid || !ren_n) begin
                    if (!ram_empty) begin
                        load     = 1'b1;
                        ptr_nx   = rptr + PW'(1);
                        valid_nx = 1'b1;
                    end else begin
                        valid_nx = 1'b0;
                    end
                end
            end
            RD_SETUP_A: begin
                load = 1'b0;
            end
            RD_SETUP_B: begin
                if (mode_fwft && !ram_empty) begin
                    load     = 1'b1;
                    ptr_nx   = rptr + PW'(1);
                    valid_nx = 1'b1;
                end
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr      <= '0;
            rptr_gray <= '0;
            valid     <= 1'b0;
            dout      <= '0;
            rt_err    <= 1'b0;
            occ_q     <= '0;
            ae_n      <= 1'b0;
        end else begin
            rptr      <= ptr_nx;
            rptr_gray <= ptr_nx ^ (ptr_nx >> 1);
            valid     <= valid_nx;
            if (load) begin
                dout <= rdata;
            end
            rt_err <= rt_bad;
            occ_q  <= occ;
            ae_n   <= !(occ_q <= AE_V);
        end
    end

    // outputs
    always_comb begin
        if (mode_fwft) begin
            rd_stat = !((st == RD_RUN) && valid);
        end else begin
            rd_stat = (st == RD_RUN) && !ram_empty;
        end
        hf_n = !(occ > HALF_V);
    end

endmodule

// File: rtl/rtf_replay_fifo.sv
module rtf_replay_fifo
    import rtf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 4
) (
    input  logic          rst_n,
    input  logic          mode_fwft,
    input  logic          rt_zero_lat,
    input  logic          wclk,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          rclk,
    input  logic          ren_n,
    input  logic          rt_n,
    output logic [DW-1:0] dout,
    output logic          rd_stat,
    output logic          ae_n,
    output logic          hf_n,
    output logic          af_n,
    output logic          rt_err
);

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata;
    logic [AW:0]   wptr_gray, rptr_gray, rd_ptr, wr_occ;
    logic          over_lim;
    rd_state_e     rd_st;

    rtf_store #(.DW(DW), .AW(AW)) u_store (
        .wclk (wclk),
        .we   (we),
        .waddr(waddr),
        .wdata(din),
        .raddr(raddr),
        .rdata(rdata)
    );

    rtf_wr_side #(.AW(AW), .AF_OFS(AF_OFS)) u_wr (
        .wclk     (wclk),
        .rst_n    (rst_n),
        .mode_fwft(mode_fwft),
        .wen_n    (wen_n),
        .rptr_gray(rptr_gray),
        .we       (we),
        .waddr    (waddr),
        .wptr_gray(wptr_gray),
        .over_lim (over_lim),
        .af_n     (af_n),
        .wocc     (wr_occ)
    );

    rtf_rd_side #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS)) u_rd (
        .rclk       (rclk),
        .rst_n      (rst_n),
        .mode_fwft  (mode_fwft),
        .rt_zero_lat(rt_zero_lat),
        .ren_n      (ren_n),
        .rt_n       (rt_n),
        .wen_n      (wen_n),
        .over_lim   (over_lim),
        .wptr_gray  (wptr_gray),
        .rdata      (rdata),
        .raddr      (raddr),
        .rptr_gray  (rptr_gray),
        .rptr       (rd_ptr),
        .dout       (dout),
        .rd_stat    (rd_stat),
        .ae_n       (ae_n),
        .hf_n       (hf_n),
        .rt_err     (rt_err),
        .st         (rd_st)
    );

endmodule

// File: rtl/rtf_replay_fifo_chk.sv
module rtf_replay_fifo_chk
    import rtf_pkg::*;
#(
    parameter int AW = 4
) (
    input logic        rclk,
    input logic        wclk,
    input logic        rst_n,
    input logic        mode_fwft,
    input logic        rt_n,
    input logic        rt_err,
    input logic        rd_stat,
    input rd_state_e   st,
    input logic [AW:0] rptr,
    input logic [AW:0] wocc
);

    localparam int DEPTH = 1 << AW;

    a_r5_setup_a_then_b: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == RD_SETUP_A) |=> (st == RD_SETUP_B));

    a_r5_setup_b_then_run: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == RD_SETUP_B) |=> (st == RD_RUN));

    a_r4_rewound_to_zero: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == RD_SETUP_A) |-> (rptr == '0));

    a_r6_flag_during_setup: assert property (@(posedge rclk) disable iff (!rst_n)
        (st != RD_RUN) |-> (rd_stat == mode_fwft));

    a_r11_err_after_request: assert property (@(posedge rclk) disable iff (!rst_n)
        rt_err |-> $past(!rt_n));

    a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        wocc <= (AW+1)'(DEPTH));

endmodule

bind rtf_replay_fifo rtf_replay_fifo_chk #(.AW(AW)) u_chk (
    .rclk     (rclk),
    .wclk     (wclk),
    .rst_n    (rst_n),
    .mode_fwft(mode_fwft),
    .rt_n     (rt_n),
    .rt_err   (rt_err),
    .rd_stat  (rd_stat),
    .st       (rd_st),
    .rptr     (rd_ptr),
    .wocc     (wr_occ)
);

// File: tb/tb_rtf_replay_fifo.sv
module tb_rtf_replay_fifo;

    logic        clk = 1'b0;
    logic        rst_n, mode_fwft, rt_zero_lat, wen_n, ren_n, rt_n;
    logic [15:0] din, dout;
    logic        rd_stat, ae_n, hf_n, af_n, rt_err;

    always #10 clk = ~clk;

    rtf_replay_fifo dut (
        .rst_n(rst_n), .mode_fwft(mode_fwft), .rt_zero_lat(rt_zero_lat),
        .wclk(clk), .wen_n(wen_n), .din(din),
        .rclk(clk), .ren_n(ren_n), .rt_n(rt_n),
        .dout(dout), .rd_stat(rd_stat), .ae_n(ae_n), .hf_n(hf_n),
        .af_n(af_n), .rt_err(rt_err)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        mon_ev;

    function automatic logic [15:0] wv(int k, int i);
        return 16'(k * 256 + i + 64);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // scoreboard monitor: compares dout with the oldest expected word
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() != 0) begin
                check(tag_q.pop_front(), 32'(dout), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_word(string req, logic [15:0] v);
        exp_q.push_back(v);
        tag_q.push_back(req);
        -> mon_ev;
    endtask

    task automatic do_reset(logic f, logic z);
        mode_fwft = f; rt_zero_lat = z;
        wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1; din = '0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        check("R1 rd_stat", 32'(rd_stat), 32'(f));
        check("R1 ae_n", 32'(ae_n), 0);
        check("R1 hf_n", 32'(hf_n), 1);
        check("R1 af_n", 32'(af_n), 1);
        check("R1 rt_err", 32'(rt_err), 0);
    endtask

    task automatic write_n(int n, int k);
        for (int i = 0; i < n; i++) begin
            wen_n = 1'b0; din = wv(k, i);
            step();
        end
        wen_n = 1'b1;
    endtask

    // one read per edge; dout checked after each edge (R2 / R3 order)
    task automatic read_run(int first, int count, int k, string req);
        for (int i = 0; i < count; i++) begin
            ren_n = 1'b0;
            step();
            expect_word(req, wv(k, first + i));
        end
        ren_n = 1'b1;
    endtask

    task automatic run_combo(logic f, logic z, int k);
        do_reset(f, z);
        write_n(13, k);
        repeat (6) step();
        if (f) begin
            check("R3 ready", 32'(rd_stat), 0);
            expect_word("R3 first word", wv(k, 0));
        end else begin
            check("R2 not empty", 32'(rd_stat), 1);
        end
        if (f && z) begin
            // R12: nothing consumed yet
            rt_n = 1'b0; step(); rt_n = 1'b1;
            check("R12 err", 32'(rt_err), 1);
            check("R12 dout kept", 32'(dout), 32'(wv(k, 0)));
            check("R12 rd_stat", 32'(rd_stat), 0);
            step();
            check("R12 err one cycle", 32'(rt_err), 0);
        end
        if (!f && !z) begin
            read_run(0, 10, k, "R2");
            // R11: request with ren_n low in normal latency
            ren_n = 1'b0; rt_n = 1'b0; step(); ren_n = 1'b1; rt_n = 1'b1;
            check("R11 err", 32'(rt_err), 1);
            expect_word("R11 read kept", wv(k, 10));
            step();
            check("R11 err one cycle", 32'(rt_err), 0);
        end else if (!f) begin
            read_run(0, 11, k, "R2");
        end else begin
            read_run(1, 11, k, "R3");
        end
        repeat (3) step();
        check("R8 ae before", 32'(ae_n), 0);
        check("R9 hf before", 32'(hf_n), 1);
        check("R10 af before", 32'(af_n), 1);
        // accepted retransmit
        rt_n = 1'b0;
        if (!f && z) ren_n = 1'b0;   // R7: read enable may be low
        step();
        rt_n = 1'b1; ren_n = 1'b1;
        check("R4 accepted", 32'(rt_err), 0);
        check("R9 hf at edge", 32'(hf_n), 0);
        if (z) begin
            check("R7 word0", 32'(dout), 32'(wv(k, 0)));
            check("R7 rd_stat", 32'(rd_stat), 32'(!f));
        end else begin
            check(f ? "R6 setup1" : "R5 setup1", 32'(rd_stat), 32'(f));
        end
        step();
        check("R8 ae after 1", 32'(ae_n), 0);
        check("R10 af after 1", 32'(af_n), 1);
        if (!z) check(f ? "R6 setup2" : "R5 setup2", 32'(rd_stat), 32'(f));
        step();
        check("R8 ae after 2", 32'(ae_n), 1);
        check("R10 af after 2", 32'(af_n), 0);
        if (!z) begin
            check(f ? "R6 done" : "R5 done", 32'(rd_stat), 32'(!f));
            if (f) check("R6 word0", 32'(dout), 32'(wv(k, 0)));
        end
        if (!f && !z) begin
            read_run(0, 13, k, "R4");
        end else begin
            read_run(1, 12, k, "R4");
        end
        step();
        check("R2 final rd_stat", 32'(rd_stat), 0);
    endtask

    initial begin
        rst_n = 1'b0; mode_fwft = 1'b0; rt_zero_lat = 1'b0;
        wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1; din = '0;
        run_combo(1'b0, 1'b0, 0);
        run_combo(1'b0, 1'b1, 1);
        run_combo(1'b1, 1'b0, 2);
        run_combo(1'b1, 1'b1, 3);
        // R12: too many words written since reset (15 > DEPTH-2)
        do_reset(1'b0, 1'b0);
        write_n(15, 4);
        repeat (6) step();
        read_run(0, 3, 4, "R2");
        repeat (2) step();
        rt_n = 1'b0; step(); rt_n = 1'b1;
        check("R12 over err", 32'(rt_err), 1);
        check("R12 no setup", 32'(rd_stat), 1);
        step();
        check("R12 still ready", 32'(rd_stat), 1);
        read_run(3, 1, 4, "R12 pointer kept");
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule